// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block holds the timestamp of one precision-time event packet per direction. When the transmit path flags a packet for stamping, or the receive path presents a packet whose header fields, already parsed upstream, pass the configured receive filter, the block copies the running time counter into a 64-bit holding register. It then raises a valid flag. Once valid is set, the register is locked: later qualifying packets in that direction are not stamped. The lock stays until software has read the upper half of the register.

Software reads each stamp as two 32-bit halves, low half first and then high half, through a small read port. The read of the high half frees the register for the next event. The receive filter has four modes:
- layer-4 version-1 messages of one chosen message type on the event UDP port;
- version-2 event messages, including the peer-delay pair, carried over UDP or over layer 2 with the timing Ethertype;
- any frame that hits the Ethertype filter entry;
- off.

Clearing a direction's enable drops its valid flag and releases its lock.

Top module: `ts_capture`

## Requirements
- R1: After reset both valid flags are 0 and both stamps read as 0.
- R2: With `tx_enable` high and `tx_valid` low, a one-cycle `tx_evt` sets `tx_valid` after the next clock edge. The transmit stamp then equals the `time_now` value present in the strobe cycle. The same rule applies to the receive side with `rx_evt` when the receive filter matches.
- R3: While a direction's valid flag is set, further events in that direction leave its stamp and its valid flag unchanged.
- R4: `rd_dir` selects the register (0 transmit, 1 receive) and `rd_hi` selects the half (0 gives stamp bits 31:0, 1 gives bits 63:32). `rd_data` reflects the selection combinationally. A cycle with `rd_en` and `rd_hi` high clears the selected valid flag at the next edge. A read of the low half does not clear it.
- R5: While a direction's enable is low, its valid flag is 0 from the next edge and its events are ignored.
- R6: Receive mode 0 (layer-4 version 1) matches only when all of these hold: the frame is UDP, the destination port equals `rx_port`, the version field is 1, and the message type equals `rx_v1_msg`.
- R7: Receive mode 1 (version-2 event) matches a version-2 message with type 0 to 3. Types 2 and 3 are the peer-delay messages. The frame must be UDP to `rx_port`, or layer 2 with an Ethertype that hits the filter entry. Types above 3 never match.
- R8: Receive mode 2 (Ethertype) matches a layer-2 frame whose Ethertype equals `etf_type`, with any version, but only while both `etf_enable` and `etf_stamp` are 1.
- R9: Receive mode 3 never matches.
- R10: A receive event that does not match leaves `rx_valid` low.
- R11: Capture, lock and release in one direction have no effect on the other direction.
- R12: An event in the same cycle as a high-half read of a locked register is not captured. The valid flag still clears and the stamp keeps the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Running time counter |
| tx_enable | input | 1 | Transmit stamping enable |
| tx_evt | input | 1 | Transmit packet marked for stamping |
| rx_enable | input | 1 | Receive stamping enable |
| rx_mode | input | 2 | Receive filter mode (0 L4 v1, 1 v2 event, 2 Ethertype, 3 off) |
| rx_port | input | 16 | Event UDP destination port |
| rx_v1_msg | input | 4 | Version-1 message type to match |
| etf_enable | input | 1 | Ethertype filter entry enable |
| etf_stamp | input | 1 | Ethertype filter entry stamp enable |
| etf_type | input | 16 | Ethertype value of the filter entry |
| rx_evt | input | 1 | Receive packet header fields valid |
| rx_is_l2 | input | 1 | Frame carries the timing message directly over layer 2 |
| rx_ethertype | input | 16 | Frame Ethertype |
| rx_is_udp | input | 1 | Frame is UDP |
| rx_udp_dport | input | 16 | UDP destination port |
| rx_ver | input | 4 | Timing message version |
| rx_msg | input | 4 | Timing message type |
| rd_en | input | 1 | Read strobe |
| rd_dir | input | 1 | Read select: 0 transmit, 1 receive |
| rd_hi | input | 1 | Read half: 0 low, 1 high |
| rd_data | output | 32 | Selected stamp half |
| tx_valid | output | 1 | Transmit stamp held |
| rx_valid | output | 1 | Receive stamp held |

## Verification
A capture takes exactly one register stage. The valid flag and the stamp change at the edge that ends the strobe cycle, so the bench drives each event on a falling edge and checks valid and stamp at the following falling edge. `rd_data` has no register stage: it is sampled one time unit after the select is driven, within the same cycle. A high-half read takes effect at the next edge, so the release is checked one falling edge after the read strobe, and the bench confirms the register accepts a new capture after that.

// File: rtl/ts_pkg.sv
package ts_pkg;

   typedef enum logic [1:0] {
      RXM_L4_V1    = 2'd0,
      RXM_V2_EVENT = 2'd1,
      RXM_ETYPE    = 2'd2,
      RXM_OFF      = 2'd3
   } rx_mode_e;

   localparam int DIR_TX   = 0;
   localparam int DIR_RX   = 1;
   localparam int NUM_DIR  = 2;

   localparam int VER_ONE  = 1;
   localparam int VER_TWO  = 2;
   // highest version-2 message type that is an event message
   localparam int V2_EVENT_MAX = 3;

endpackage

// File: rtl/ts_rx_match.sv
module ts_rx_match
   import ts_pkg::*;
#(
   parameter int PORT_W  = 16,
   parameter int ETYPE_W = 16,
   parameter int VER_W   = 4,
   parameter int MSG_W   = 4
) (
   input  logic [1:0]         mode_i,
   input  logic [PORT_W-1:0]  port_i,
   input  logic [MSG_W-1:0]   v1_msg_i,
   input  logic               etf_en_i,
   input  logic               etf_stamp_i,
   input  logic [ETYPE_W-1:0] etf_type_i,
   input  logic               is_l2_i,
   input  logic [ETYPE_W-1:0] etype_i,
   input  logic               is_udp_i,
   input  logic [PORT_W-1:0]  dport_i,
   input  logic [VER_W-1:0]   ver_i,
   input  logic [MSG_W-1:0]   msg_i,
   output logic               hit_o
);

   localparam logic [VER_W-1:0] VER1   = VER_W'(VER_ONE);
   localparam logic [VER_W-1:0] VER2   = VER_W'(VER_TWO);
   localparam logic [MSG_W-1:0] EVTMAX = MSG_W'(V2_EVENT_MAX);

   generate
      if (VER_W < 2) begin : g_bad_ver
         $error("ts_rx_match: VER_W must hold version 2");
      end
      if (MSG_W < 2) begin : g_bad_msg
         $error("ts_rx_match: MSG_W must hold event type 3");
      end
   endgenerate

   rx_mode_e mode;
   logic     udp_ok;
   logic     etf_ok;
   logic     v1_ok;
   logic     v2_ok;

   always_comb begin
      mode   = rx_mode_e'(mode_i);
      udp_ok = is_udp_i && (dport_i == port_i);
      etf_ok = is_l2_i && etf_en_i && etf_stamp_i && (etype_i == etf_type_i);
      v1_ok  = (ver_i == VER1) && (msg_i == v1_msg_i);
      v2_ok  = (ver_i == VER2) && (msg_i <= EVTMAX);
      unique case (mode)
         RXM_L4_V1:    hit_o = udp_ok && v1_ok;
         RXM_V2_EVENT: hit_o = v2_ok && (udp_ok || etf_ok);
         RXM_ETYPE:    hit_o = etf_ok;
         default:      hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ts_latch.sv
module ts_latch #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              hit_i,
   input  logic              rel_i,
   input  logic [TIME_W-1:0] time_i,
   output logic              valid_o,
   output logic [TIME_W-1:0] stamp_o
);

   logic              valid_q;
   logic [TIME_W-1:0] stamp_q;
   logic              take;

   assign take = en_i && hit_i && !valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         stamp_q <= '0;
      end else begin
         if (take) stamp_q <= time_i;
         if (!en_i)                  valid_q <= 1'b0;
         else if (valid_q && rel_i)  valid_q <= 1'b0;
         else if (take)              valid_q <= 1'b1;
      end
   end

   assign valid_o = valid_q;
   assign stamp_o = stamp_q;

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && hit_i && !valid_o) |=> (valid_o && stamp_o == $past(time_i)));

   a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && en_i && !rel_i) |=> (valid_o && $stable(stamp_o)));

   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && rel_i) |=> (!valid_o && $stable(stamp_o)));

   a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i) |=> (!valid_o && $stable(stamp_o)));

endmodule

// File: rtl/ts_capture.sv
module ts_capture
   import ts_pkg::*;
#(
   parameter int TIME_W  = 64,
   parameter int RD_W    = 32,
   parameter int PORT_W  = 16,
   parameter int ETYPE_W = 16,
   parameter int VER_W   = 4,
   parameter int MSG_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIME_W-1:0]  time_now,
   input  logic               tx_enable,
   input  logic               tx_evt,
   input  logic               rx_enable,
   input  logic [1:0]         rx_mode,
   input  logic [PORT_W-1:0]  rx_port,
   input  logic [MSG_W-1:0]   rx_v1_msg,
   input  logic               etf_enable,
   input  logic               etf_stamp,
   input  logic [ETYPE_W-1:0] etf_type,
   input  logic               rx_evt,
   input  logic               rx_is_l2,
   input  logic [ETYPE_W-1:0] rx_ethertype,
   input  logic               rx_is_udp,
   input  logic [PORT_W-1:0]  rx_udp_dport,
   input  logic [VER_W-1:0]   rx_ver,
   input  logic [MSG_W-1:0]   rx_msg,
   input  logic               rd_en,
   input  logic               rd_dir,
   input  logic               rd_hi,
   output logic [RD_W-1:0]    rd_data,
   output logic               tx_valid,
   output logic               rx_valid
);

   localparam int NHALF = TIME_W / RD_W;

   generate
      if (NHALF != 2 || TIME_W != NHALF * RD_W) begin : g_bad_width
         $error("ts_capture: TIME_W must be exactly two read words");
      end
   endgenerate

   logic              rx_hit;
   logic [NUM_DIR-1:0] dir_en;
   logic [NUM_DIR-1:0] dir_hit;
   logic [NUM_DIR-1:0] dir_rel;
   logic [NUM_DIR-1:0] dir_valid;
   logic [TIME_W-1:0]  dir_stamp [NUM_DIR];

   ts_rx_match #(
      .PORT_W (PORT_W),
      .ETYPE_W(ETYPE_W),
      .VER_W  (VER_W),
      .MSG_W  (MSG_W)
   ) u_match (
      .mode_i     (rx_mode),
      .port_i     (rx_port),
      .v1_msg_i   (rx_v1_msg),
      .etf_en_i   (etf_enable),
      .etf_stamp_i(etf_stamp),
      .etf_type_i (etf_type),
      .is_l2_i    (rx_is_l2),
      .etype_i    (rx_ethertype),
      .is_udp_i   (rx_is_udp),
      .dport_i    (rx_udp_dport),
      .ver_i      (rx_ver),
      .msg_i      (rx_msg),
      .hit_o      (rx_hit)
   );

   assign dir_en[DIR_TX]  = tx_enable;
   assign dir_en[DIR_RX]  = rx_enable;
   assign dir_hit[DIR_TX] = tx_evt;
   assign dir_hit[DIR_RX] = rx_evt && rx_hit;

   generate
      for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
         assign dir_rel[d] = rd_en && rd_hi && (int'(rd_dir) == d);
         ts_latch #(.TIME_W(TIME_W)) u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (dir_en[d]),
            .hit_i  (dir_hit[d]),
            .rel_i  (dir_rel[d]),
            .time_i (time_now),
            .valid_o(dir_valid[d]),
            .stamp_o(dir_stamp[d])
         );
      end
   endgenerate

   always_comb begin
      rd_data = dir_stamp[rd_dir][(rd_hi ? RD_W : 0) +: RD_W];
   end

   assign tx_valid = dir_valid[DIR_TX];
   assign rx_valid = dir_valid[DIR_RX];

   // R9: mode 3 never opens the receive register
   a_r9_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && rx_mode == 2'd3 && !rx_valid) |=> !rx_valid);

   // R7: general (non-event) version-2 messages are not stamped
   a_r7_general_msg: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && rx_mode == 2'd1 && rx_msg > MSG_W'(V2_EVENT_MAX) && !rx_valid)
      |=> !rx_valid);

   // R11: a transmit strobe alone never raises the receive flag
   a_r11_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_evt && !rx_evt && !rx_valid) |=> !rx_valid);

   // R1: flags are low in the first cycle after reset
   a_r1_reset: assert property (@(posedge clk)
      (!rst_n) |=> (!tx_valid && !rx_valid));

endmodule

// File: tb/tb_ts_capture.sv
module tb_ts_capture;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] time_now;
   logic        tx_enable, tx_evt, rx_enable;
   logic [1:0]  rx_mode;
   logic [15:0] rx_port;
   logic [3:0]  rx_v1_msg;
   logic        etf_enable, etf_stamp;
   logic [15:0] etf_type;
   logic        rx_evt, rx_is_l2, rx_is_udp;
   logic [15:0] rx_ethertype, rx_udp_dport;
   logic [3:0]  rx_ver, rx_msg;
   logic        rd_en, rd_dir, rd_hi;
   logic [31:0] rd_data;
   logic        tx_valid, rx_valid;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   ts_capture dut (
      .clk(clk), .rst_n(rst_n), .time_now(time_now),
      .tx_enable(tx_enable), .tx_evt(tx_evt), .rx_enable(rx_enable),
      .rx_mode(rx_mode), .rx_port(rx_port), .rx_v1_msg(rx_v1_msg),
      .etf_enable(etf_enable), .etf_stamp(etf_stamp), .etf_type(etf_type),
      .rx_evt(rx_evt), .rx_is_l2(rx_is_l2), .rx_ethertype(rx_ethertype),
      .rx_is_udp(rx_is_udp), .rx_udp_dport(rx_udp_dport),
      .rx_ver(rx_ver), .rx_msg(rx_msg),
      .rd_en(rd_en), .rd_dir(rd_dir), .rd_hi(rd_hi), .rd_data(rd_data),
      .tx_valid(tx_valid), .rx_valid(rx_valid)
   );

   // vector: mode[44:43] l2[42] etype[41:26] udp[25] dport[24:9] ver[8:5] msg[4:1] exp[0]
   localparam int NV = 15;
   localparam logic [44:0] VEC [NV] = '{
      {2'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 4'd0, 1'b1},
      {2'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 4'd1, 1'b0},
      {2'd0, 1'b0, 16'h0800, 1'b1, 16'd320, 4'd1, 4'd0, 1'b0},
      {2'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 4'd0, 1'b0},
      {2'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd1, 4'd0, 1'b0},
      {2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 4'd0, 1'b1},
      {2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 4'd2, 1'b1},
      {2'd1, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd3, 1'b1},
      {2'd1, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd8, 1'b0},
      {2'd1, 1'b1, 16'h0800, 1'b0, 16'd0,   4'd2, 4'd0, 1'b0},
      {2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 4'd0, 1'b0},
      {2'd2, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd1, 4'd9, 1'b1},
      {2'd2, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 4'd0, 1'b0},
      {2'd3, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 4'd0, 1'b0},
      {2'd3, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 4'd0, 1'b0}
   };

   function automatic string mode_req(input logic [1:0] m);
      case (m)
         2'd0:    return "R6";
         2'd1:    return "R7";
         2'd2:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse_tx(input logic [63:0] t);
      @(negedge clk);
      time_now = t; tx_evt = 1'b1;
      @(negedge clk);
      tx_evt = 1'b0;
   endtask

   task automatic pulse_rx(input logic [63:0] t);
      @(negedge clk);
      time_now = t; rx_evt = 1'b1;
      @(negedge clk);
      rx_evt = 1'b0;
   endtask

   task automatic set_rx(input logic [44:0] v);
      rx_mode      = v[44:43];
      rx_is_l2     = v[42];
      rx_ethertype = v[41:26];
      rx_is_udp    = v[25];
      rx_udp_dport = v[24:9];
      rx_ver       = v[8:5];
      rx_msg       = v[4:1];
   endtask

   // read one half; a high read is held for one edge and so releases the lock
   task automatic rd(input logic dir, input logic hi, output logic [31:0] val);
      @(negedge clk);
      rd_en = 1'b1; rd_dir = dir; rd_hi = hi;
      #1 val = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v32;
      rst_n = 1'b0; time_now = '0;
      tx_enable = 1'b1; tx_evt = 1'b0; rx_enable = 1'b1; rx_evt = 1'b0;
      rx_port = 16'd319; rx_v1_msg = 4'd0;
      etf_enable = 1'b1; etf_stamp = 1'b1; etf_type = 16'h88F7;
      set_rx(VEC[0]);
      rd_en = 1'b0; rd_dir = 1'b0; rd_hi = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 tx_valid", 64'(tx_valid), 64'd0);
      check("R1 rx_valid", 64'(rx_valid), 64'd0);
      rd_dir = 1'b0; rd_hi = 1'b1; #1 check("R1 tx hi", 64'(rd_data), 64'd0);
      rd_dir = 1'b1; rd_hi = 1'b0; #1 check("R1 rx lo", 64'(rd_data), 64'd0);

      // table walk over receive filter modes (R6 R7 R8 R9 R10)
      for (int i = 0; i < NV; i++) begin
         logic [63:0] t;
         t = 64'h1234_0000_0000_0000 + 64'(i) * 64'h0000_0101_0000_0011;
         set_rx(VEC[i]);
         pulse_rx(t);
         check({mode_req(VEC[i][44:43]), VEC[i][0] ? " match" : " R10 reject"},
               64'(rx_valid), 64'(VEC[i][0]));
         if (rx_valid) begin
            rd(1'b1, 1'b0, v32);
            check("R2 rx stamp lo", 64'(v32), 64'(t[31:0]));
            rd(1'b1, 1'b1, v32);
            check("R2 rx stamp hi", 64'(v32), 64'(t[63:32]));
            check("R4 rx release", 64'(rx_valid), 64'd0);
         end
      end

      // R8 with filter entry disabled, then stamp bit cleared
      set_rx(VEC[11]);
      etf_enable = 1'b0;
      pulse_rx(64'h55);
      check("R8 filter off", 64'(rx_valid), 64'd0);
      etf_enable = 1'b1; etf_stamp = 1'b0;
      pulse_rx(64'h56);
      check("R8 stamp off", 64'(rx_valid), 64'd0);
      etf_stamp = 1'b1;

      // R2 transmit capture
      pulse_tx(64'hAAAA_0001_BBBB_0002);
      check("R2 tx_valid", 64'(tx_valid), 64'd1);
      // R3 lock: later event does not overwrite
      pulse_tx(64'hDEAD_BEEF_0000_0000);
      check("R3 tx still valid", 64'(tx_valid), 64'd1);
      // R4 low read keeps lock
      rd(1'b0, 1'b0, v32);
      check("R3 tx lo kept", 64'(v32), 64'hBBBB_0002);
      check("R4 lo no release", 64'(tx_valid), 64'd1);
      // R11 rx capture while tx locked
      set_rx(VEC[0]);
      pulse_rx(64'h0000_0007_0000_0009);
      check("R11 rx captured", 64'(rx_valid), 64'd1);
      rd(1'b0, 1'b1, v32);
      check("R4 tx hi", 64'(v32), 64'hAAAA_0001);
      check("R4 tx release", 64'(tx_valid), 64'd0);
      check("R11 rx unaffected", 64'(rx_valid), 64'd1);
      rd(1'b1, 1'b0, v32);
      check("R11 rx stamp", 64'(v32), 64'h0000_0009);
      rd(1'b1, 1'b1, v32);

      // R5 disable clears valid and ignores events
      pulse_tx(64'h11);
      check("R2 tx recapture", 64'(tx_valid), 64'd1);
      @(negedge clk); tx_enable = 1'b0;
      @(negedge clk);
      check("R5 disable clears", 64'(tx_valid), 64'd0);
      pulse_tx(64'h22);
      check("R5 event ignored", 64'(tx_valid), 64'd0);
      tx_enable = 1'b1;
      @(negedge clk);
      check("R5 still clear", 64'(tx_valid), 64'd0);

      // R12 event coincident with high read of locked register
      pulse_tx(64'h0000_0003_0000_0033);
      @(negedge clk);
      rd_en = 1'b1; rd_dir = 1'b0; rd_hi = 1'b1; tx_evt = 1'b1;
      time_now = 64'h0000_0004_0000_0044;
      @(negedge clk);
      rd_en = 1'b0; tx_evt = 1'b0;
      check("R12 released", 64'(tx_valid), 64'd0);
      rd_hi = 1'b0; #1 check("R12 stamp kept", 64'(rd_data), 64'h0000_0033);
      pulse_tx(64'h0000_0005_0000_0055);
      check("R12 next capture", 64'(tx_valid), 64'd1);
      rd(1'b0, 1'b0, v32);
      check("R12 next stamp", 64'(v32), 64'h0000_0055);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule